// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches two slow digital clocks: the divided reference, which serves as the phase reference, and the divided feedback clock. It measures the time between their matching rising edges in periods of a fast sampling clock. Both slow clocks are asynchronous to the sampling clock, so each one passes through a multi-flop synchronizer before its rising edge is detected.

A two-bit window code selects one of four allowed phase errors: 2.1 ns, 4.6 ns, 7.2 ns or 19.9 ns. A parameter gives the sampling period, and the block turns each window into a whole number of sampling ticks. Lock is declared only after a run of consecutive in-window edge pairs whose length is set by a parameter. A single pair outside the window clears lock at once, and so does a cycle slip, which is two edges of the same clock with no edge of the other clock between them. In either case the run count returns to zero. The lock state drives a pin output and a status bit.

Top module: `pll_lock_detect`

## Requirements
- R1: While `rst_smp_n` is low, and after it is released before any edge pair arrives, `lock_pin_o` is 0. Asserting reset while locked clears lock.
- R2: The phase error of a pair is the number of sampling-clock rising edges between the rising edge seen on one slow clock and the rising edge seen on the other. Either clock may lead. Edges seen in the same sampling cycle have an error of 0.
- R3: The window limit in ticks is floor(W / `SAMPLE_PS`). W is 2100, 4600, 7200 or 19900 ps for `win_code_i` = 2'b00, 2'b01, 2'b10 or 2'b11. A pair is good when its error is less than or equal to the limit.
- R4: `lock_pin_o` rises on the `LOCK_RUN`-th consecutive good pair and stays high while further pairs are good.
- R5: A pair whose error exceeds the limit clears lock, and `LOCK_RUN` new good pairs are then needed to relock.
- R6: Two reference rising edges with no feedback rising edge between them are a slip. A slip clears lock and restarts the run.
- R7: Two feedback rising edges with no reference rising edge between them are a slip. A slip clears lock and restarts the run.
- R8: `lock_stat_o` always equals `lock_pin_o`.
- R9: A slow clock edge on an input that completes a pair changes the lock outputs at the fourth rising sampling-clock edge after it, not before. The default is two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Fast sampling clock |
| rst_smp_n | input | 1 | Active-low reset, synchronous to clk_smp |
| ref_div_i | input | 1 | Divided reference clock (phase reference), asynchronous |
| fb_div_i | input | 1 | Divided feedback clock, asynchronous |
| win_code_i | input | 2 | Lock window code |
| lock_pin_o | output | 1 | Lock indication for the pin |
| lock_stat_o | output | 1 | Lock indication for the status bit |

## Verification
A wrong run count or a wrong window limit shows up as a lock edge one pair too early or too late. It can also show up as lock surviving a pair that is just past the window. The bench catches these by stepping the edge offset to exactly the limit and to one tick beyond it for every window code. A stuck pending flag in the phase measurement shows up as a missed slip, which leaves lock high after a doubled edge within the next pair. A wrong synchronizer depth shifts the lock transition by whole sampling cycles, and the latency check exposes this at the fourth edge.

// File: rtl/ld_pkg.sv
package ld_pkg;

   typedef enum logic [1:0] {
      WIN_2P1NS  = 2'b00,
      WIN_4P6NS  = 2'b01,
      WIN_7P2NS  = 2'b10,
      WIN_19P9NS = 2'b11
   } win_code_e;

   // Window width in picoseconds for a code value.
   function automatic int win_width_ps(input int code);
      case (code)
         0:       return 2100;
         1:       return 4600;
         2:       return 7200;
         default: return 19900;
      endcase
   endfunction

   // Window width in whole sampling ticks, rounded down.
   function automatic int win_ticks(input int code, input int sample_ps);
      return win_width_ps(code) / sample_ps;
   endfunction

endpackage

// File: rtl/ld_edge_sync.sv
module ld_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ld_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   // sh[STAGES-1:0] is the synchronizer chain; sh[STAGES] holds the previous sample.
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], async_i};
   end

   assign rise_o = sh[STAGES-1] & ~sh[STAGES];

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R9

endmodule

// File: rtl/ld_phase_meas.sv
module ld_phase_meas #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_ev_i,
   input  logic             fb_ev_i,
   input  logic [CNT_W-1:0] lim_i,
   output logic             good_o,
   output logic             bad_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             pend_ref_q, pend_fb_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_ref_d, pend_fb_d;
   logic [CNT_W-1:0] cnt_d, cnt_inc, diff;
   logic             done, slip;

   assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;

   always_comb begin
      pend_ref_d = pend_ref_q;
      pend_fb_d  = pend_fb_q;
      cnt_d      = cnt_inc;
      done       = 1'b0;
      slip       = 1'b0;
      diff       = '0;
      if (!pend_ref_q && !pend_fb_q) begin
         if (ref_ev_i && fb_ev_i) begin
            done = 1'b1;
         end else if (ref_ev_i) begin
            pend_ref_d = 1'b1;
            cnt_d      = CNT_ONE;
         end else if (fb_ev_i) begin
            pend_fb_d = 1'b1;
            cnt_d     = CNT_ONE;
         end
      end else if (pend_ref_q) begin
         if (ref_ev_i) begin
            slip = 1'b1;
            if (fb_ev_i) pend_ref_d = 1'b0;
            else         cnt_d      = CNT_ONE;
         end else if (fb_ev_i) begin
            done       = 1'b1;
            diff       = cnt_q;
            pend_ref_d = 1'b0;
         end
      end else begin
         if (fb_ev_i) begin
            slip = 1'b1;
            if (ref_ev_i) pend_fb_d = 1'b0;
            else          cnt_d     = CNT_ONE;
         end else if (ref_ev_i) begin
            done      = 1'b1;
            diff      = cnt_q;
            pend_fb_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_ref_q <= 1'b0;
         pend_fb_q  <= 1'b0;
         cnt_q      <= '0;
         good_o     <= 1'b0;
         bad_o      <= 1'b0;
      end else begin
         pend_ref_q <= pend_ref_d;
         pend_fb_q  <= pend_fb_d;
         cnt_q      <= cnt_d;
         good_o     <= done && (diff <= lim_i);
         bad_o      <= slip || (done && (diff > lim_i));
      end
   end

   AST_ONE_LEADER: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_ref_q && pend_fb_q)); // R2
   AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(good_o && bad_o)); // R3
   AST_REF_SLIP_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_ref_q && ref_ev_i) |=> bad_o); // R6
   AST_FB_SLIP_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_fb_q && fb_ev_i) |=> bad_o); // R7
   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_ref_q || pend_fb_q) && !ref_ev_i && !fb_ev_i && cnt_q == CNT_MAX)
      |=> cnt_q == CNT_MAX); // R2

endmodule

// File: rtl/ld_lock_qual.sv
module ld_lock_qual #(
   parameter int LOCK_RUN = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic good_i,
   input  logic bad_i,
   output logic lock_o
);
   localparam int RUN_W = $clog2(LOCK_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_TOP  = RUN_W'(LOCK_RUN);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

   generate
      if (LOCK_RUN < 1) begin : g_bad_run
         $error("ld_lock_qual: LOCK_RUN must be at least 1");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         lock_o <= 1'b0;
      end else if (bad_i) begin
         run_q  <= '0;
         lock_o <= 1'b0;
      end else if (good_i) begin
         if (run_q != RUN_TOP) run_q <= run_q + RUN_W'(1);
         lock_o <= (run_q >= RUN_LAST);
      end
   end

   AST_LOCK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(good_i)); // R4
   AST_BAD_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      bad_i |=> !lock_o); // R5
   AST_BAD_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      bad_i |=> run_q == '0); // R5
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!good_i && !bad_i) |=> $stable(lock_o)); // R4

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
   parameter int SAMPLE_PS   = 250,
   parameter int LOCK_RUN    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_smp,
   input  logic       rst_smp_n,
   input  logic       ref_div_i,
   input  logic       fb_div_i,
   input  logic [1:0] win_code_i,
   output logic       lock_pin_o,
   output logic       lock_stat_o
);
   import ld_pkg::*;

   localparam int WIN_TOP = win_ticks(3, SAMPLE_PS);
   localparam int CNT_W   = $clog2(WIN_TOP + 2);

   generate
      if (SAMPLE_PS <= 0) begin : g_bad_period
         $error("pll_lock_detect: SAMPLE_PS must be positive");
      end
      if (WIN_TOP < 1) begin : g_bad_res
         $error("pll_lock_detect: sampling period too coarse for the widest window");
      end
   endgenerate

   // Window limit table, one entry per code.
   logic [CNT_W-1:0] win_lut [4];
   genvar gw;
   generate
      for (gw = 0; gw < 4; gw++) begin : g_win
         assign win_lut[gw] = CNT_W'(win_ticks(gw, SAMPLE_PS));
      end
   endgenerate

   logic [CNT_W-1:0] lim;
   assign lim = win_lut[win_code_i];

   // Index 0: reference, index 1: feedback.
   logic [1:0] raw_clk;
   logic [1:0] rise_ev;
   assign raw_clk = {fb_div_i, ref_div_i};

   genvar gs;
   generate
      for (gs = 0; gs < 2; gs++) begin : g_sync
         ld_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk     (clk_smp),
            .rst_n   (rst_smp_n),
            .async_i (raw_clk[gs]),
            .rise_o  (rise_ev[gs])
         );
      end
   endgenerate

   logic pair_good, pair_bad;

   ld_phase_meas #(.CNT_W(CNT_W)) meas_i (
      .clk      (clk_smp),
      .rst_n    (rst_smp_n),
      .ref_ev_i (rise_ev[0]),
      .fb_ev_i  (rise_ev[1]),
      .lim_i    (lim),
      .good_o   (pair_good),
      .bad_o    (pair_bad)
   );

   logic lock_q;

   ld_lock_qual #(.LOCK_RUN(LOCK_RUN)) qual_i (
      .clk    (clk_smp),
      .rst_n  (rst_smp_n),
      .good_i (pair_good),
      .bad_i  (pair_bad),
      .lock_o (lock_q)
   );

   assign lock_pin_o  = lock_q;
   assign lock_stat_o = lock_q;

   AST_LOCK_OUT_STATUS: assert property (@(posedge clk_smp) disable iff (!rst_smp_n)
      lock_pin_o == lock_stat_o); // R8
   AST_LOCK_FLAT_NO_EDGE: assert property (@(posedge clk_smp) disable iff (!rst_smp_n)
      (rise_ev == 2'b00 && !pair_good && !pair_bad) |=> $stable(lock_pin_o)); // R9

endmodule

// File: tb/pll_lock_detect_tb_top.sv
module pll_lock_detect_tb_top;
   localparam int SPS  = 250;
   localparam int RUNS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_c = 1'b0;
   logic fb_c = 1'b0;
   logic [1:0] wcode = 2'b00;
   logic lock_pin, lock_stat;
   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pll_lock_detect #(.SAMPLE_PS(SPS), .LOCK_RUN(RUNS), .SYNC_STAGES(2)) dut_i (
      .clk_smp     (clk),
      .rst_smp_n   (rst_n),
      .ref_div_i   (ref_c),
      .fb_div_i    (fb_c),
      .win_code_i  (wcode),
      .lock_pin_o  (lock_pin),
      .lock_stat_o (lock_stat)
   );

   // Entry fields: [11:10] window code, [9] feedback leads, [8] expected lock, [7:0] offset ticks.
   // Limits for SPS=250: code 00 -> 8, 01 -> 18, 10 -> 28, 11 -> 79.
   localparam logic [11:0] VEC [0:20] = '{
      12'h000, 12'h008, 12'h203, 12'h308, 12'h009, 12'h002, 12'h005,
      12'h205, 12'h105, 12'h512, 12'h613, 12'hC28, 12'hC28, 12'hC28,
      12'hD28, 12'hE50, 12'h81C, 12'hA1C, 12'h81C, 12'hB1C, 12'h81D
   };

   task automatic chk(input string req, input logic exp_lock);
      n_chk++;
      if (lock_pin !== exp_lock) begin
         n_fail++;
         $display("FAIL %s lock_pin actual=%b expected=%b", req, lock_pin, exp_lock);
      end
      n_chk++;
      if (lock_stat !== lock_pin) begin
         n_fail++;
         $display("FAIL R8 lock_stat actual=%b expected=%b", lock_stat, lock_pin);
      end
   endtask

   task automatic pulse_pair(input int off, input bit fb_lead);
      @(negedge clk);
      if (fb_lead) fb_c = 1'b1; else ref_c = 1'b1;
      for (int i = 0; i < off; i++) @(negedge clk);
      ref_c = 1'b1;
      fb_c  = 1'b1;
      repeat (8) @(negedge clk);
      ref_c = 1'b0;
      fb_c  = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic lone_edge(input bit is_fb);
      @(negedge clk);
      if (is_fb) fb_c = 1'b1; else ref_c = 1'b1;
      repeat (8) @(negedge clk);
      ref_c = 1'b0;
      fb_c  = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 in reset", 1'b0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 after release", 1'b0);

      // Table: offsets at and past each limit, both lead orders (R2 R3 R4 R5).
      for (int k = 0; k < 21; k++) begin
         wcode = VEC[k][11:10];
         pulse_pair(int'(VEC[k][7:0]), VEC[k][9]);
         chk($sformatf("R2 R3 R4 R5 entry %0d", k), VEC[k][8]);
      end

      // R9: lock changes on the fourth sampling edge after the completing edge.
      wcode = 2'b00;
      for (int k = 0; k < RUNS - 1; k++) pulse_pair(1, 1'b0);
      chk("R4 one short of run", 1'b0);
      @(negedge clk);
      ref_c = 1'b1;
      repeat (2) @(negedge clk);
      fb_c = 1'b1;
      repeat (3) @(posedge clk);
      #1 chk("R9 before fourth edge", 1'b0);
      @(posedge clk);
      #1 chk("R9 at fourth edge", 1'b1);
      repeat (8) @(negedge clk);
      ref_c = 1'b0;
      fb_c  = 1'b0;
      repeat (6) @(negedge clk);

      // R6: reference slip.
      lone_edge(1'b0);
      chk("R6 held before slip", 1'b1);
      lone_edge(1'b0);
      chk("R6 reference slip", 1'b0);
      lone_edge(1'b1);
      chk("R6 late feedback stays unlocked", 1'b0);
      for (int k = 0; k < RUNS; k++) pulse_pair(1, 1'b0);
      chk("R4 relock after slip", 1'b1);

      // R7: feedback slip.
      lone_edge(1'b1);
      lone_edge(1'b1);
      chk("R7 feedback slip", 1'b0);
      lone_edge(1'b0);
      chk("R7 late reference stays unlocked", 1'b0);
      for (int k = 0; k < RUNS; k++) pulse_pair(0, 1'b0);
      chk("R2 zero offset relock", 1'b1);

      // R1: reset clears lock.
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 reset while locked", 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 released", 1'b0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule